// File: doc/BRIEF.md
# Bidirectional Common Scan Shift Register

This block is the row-scan register of a display driver that works as a common (row) driver. A scan token is fed in serially and moves by one stage on every falling edge of the latch pulse. The register outputs all of its stages in parallel, and the output level stage behind it turns each bit into a row select. The latch pulse is sampled on the block clock, and a falling edge seen there produces a one-cycle shift strobe.

The stages can form one long chain or two independent half-length chains. Either form can shift toward higher or lower stage numbers. The two end stages face two cascade pins so that several drivers can be chained. The pin at the head of the current direction receives data. The pin at the tail drives the last stage out to the next chip. In split mode the second half takes its own serial input at its head stage.

Top module: `common_scan_reg`

## Requirements
- R1: While `rstN` is low, every stage is cleared. After reset, both cascade outputs read 0 until the first shift.
- R2: The stages change only in the clock cycle after `latchPulse` is seen high on one clock edge and low on the next. A rising edge, or a level held for any number of cycles, leaves every stage unchanged.
- R3: Forward single mode (`dirSel`=1, `dualSel`=0): on each shift, stage 0 loads `edgeAIn` and stage i loads the old value of stage i-1 for i = 1 to STAGES-1.
- R4: Reverse single mode (`dirSel`=0, `dualSel`=0): on each shift, stage STAGES-1 loads `edgeBIn` and stage i loads the old value of stage i+1.
- R5: Forward split mode (`dirSel`=1, `dualSel`=1): stage STAGES/2 loads `secondIn` rather than stage STAGES/2-1. All other stages follow R3.
- R6: Reverse split mode (`dirSel`=0, `dualSel`=1): stage STAGES/2-1 loads `secondIn` rather than stage STAGES/2. All other stages follow R4.
- R7: When `dirSel`=1, `edgeBOe`=1 and `edgeBOut` equals stage STAGES-1, while `edgeAOe`=0 and `edgeAOut`=0. When `dirSel`=0 the roles swap: `edgeAOe`=1 and `edgeAOut` equals stage 0, while `edgeBOe`=0 and `edgeBOut`=0.
- R8: In single mode `secondIn` has no effect on any stage. In both modes the cascade input of the pin that is currently acting as the output has no effect on any stage.
- R9: In forward single mode, a 1 applied at `edgeAIn` on one shift, followed by zeros, appears at `edgeBOut` after exactly STAGES shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| latchPulse | input | 1 | Latch pulse; a falling edge advances the scan |
| dirSel | input | 1 | 1: shift toward higher stages; 0: toward lower stages |
| dualSel | input | 1 | 1: two half-length chains; 0: one chain |
| edgeAIn | input | 1 | Cascade pin at stage 0, input side |
| edgeAOut | output | 1 | Cascade pin at stage 0, output side |
| edgeAOe | output | 1 | Output enable of the stage-0 cascade pin |
| edgeBIn | input | 1 | Cascade pin at the last stage, input side |
| edgeBOut | output | 1 | Cascade pin at the last stage, output side |
| edgeBOe | output | 1 | Output enable of the last-stage cascade pin |
| secondIn | input | 1 | Serial input of the second half chain in split mode |
| scanBits | output | STAGES | Parallel stage contents for the output level stage |

## Verification
The bench builds the block with its default of 160 stages, so the full token traversal of R9 and both half-chain boundaries at stages 79 and 80 are exercised at the real size. The run mixes directions and chain modes from pulse to pulse. Because of that mix, data left behind by one mode is then shifted under another, which reaches the half-boundary mux paths with nonzero data on both sides.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef struct packed {
    logic shiftEn;  // one-cycle advance strobe
    logic fwd;      // toward higher stage numbers
    logic dual;     // split into two half chains
  } scanCtl_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     latchPulse,
  input  logic     dirSel,
  input  logic     dualSel,
  output scanCtl_t ctl
);
  logic lpPrev;

  always_ff @(posedge clk) begin
    if (!rstN) lpPrev <= 1'b0;
    else       lpPrev <= latchPulse;
  end

  always_comb begin
    ctl.shiftEn = lpPrev & ~latchPulse;
    ctl.fwd     = dirSel;
    ctl.dual    = dualSel;
  end

  // R2: a strobe only follows a high-to-low transition of the pulse
  p_strobe_on_fall_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |-> ($past(latchPulse) && !latchPulse));
endmodule

// File: rtl/scan_path.sv
module scan_path
  import scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtl_t          ctl,
  input  logic              headAIn,
  input  logic              headBIn,
  input  logic              secondIn,
  output logic [STAGES-1:0] scanBits
);
  localparam int HALF = STAGES / 2;

  logic [STAGES-1:0] scanQ, fromLow, fromHigh, scanNext;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_lowHead
      assign fromLow[i] = headAIn;
    end else if (i == HALF) begin : g_lowSplit
      assign fromLow[i] = ctl.dual ? secondIn : scanQ[i-1];
    end else begin : g_lowMid
      assign fromLow[i] = scanQ[i-1];
    end

    if (i == STAGES - 1) begin : g_highHead
      assign fromHigh[i] = headBIn;
    end else if (i == HALF - 1) begin : g_highSplit
      assign fromHigh[i] = ctl.dual ? secondIn : scanQ[i+1];
    end else begin : g_highMid
      assign fromHigh[i] = scanQ[i+1];
    end
  end

  assign scanNext = ctl.fwd ? fromLow : fromHigh;

  always_ff @(posedge clk) begin
    if (!rstN)            scanQ <= '0;
    else if (ctl.shiftEn) scanQ <= scanNext;
  end

  assign scanBits = scanQ;

  initial begin
    a_even_stages: assert (STAGES % 2 == 0 && STAGES >= 4);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |=> $stable(scanQ));
  p_fwd_head_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && ctl.fwd) |=> scanQ[0] == $past(headAIn));
  p_fwd_move_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && ctl.fwd) |=> scanQ[HALF-1:1] == $past(scanQ[HALF-2:0]));
  p_rev_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.fwd) |=> scanQ[STAGES-1] == $past(headBIn));
  p_rev_move_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.fwd) |=> scanQ[STAGES-2:HALF] == $past(scanQ[STAGES-1:HALF+1]));
  p_fwd_split_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && ctl.fwd && ctl.dual) |=> scanQ[HALF] == $past(secondIn));
  p_rev_split_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.fwd && ctl.dual) |=> scanQ[HALF-1] == $past(secondIn));
endmodule

// File: rtl/common_scan_reg.sv
module common_scan_reg
  import scan_pkg::*;
#(
  parameter int STAGES = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              latchPulse,
  input  logic              dirSel,
  input  logic              dualSel,
  input  logic              edgeAIn,
  output logic              edgeAOut,
  output logic              edgeAOe,
  input  logic              edgeBIn,
  output logic              edgeBOut,
  output logic              edgeBOe,
  input  logic              secondIn,
  output logic [STAGES-1:0] scanBits
);
  scanCtl_t ctl;

  scan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .latchPulse(latchPulse),
    .dirSel(dirSel), .dualSel(dualSel), .ctl(ctl)
  );

  scan_path #(.STAGES(STAGES)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .headAIn(edgeAIn), .headBIn(edgeBIn), .secondIn(secondIn),
    .scanBits(scanBits)
  );

  assign edgeAOe  = ~ctl.fwd;
  assign edgeBOe  = ctl.fwd;
  assign edgeAOut = edgeAOe & scanBits[0];
  assign edgeBOut = edgeBOe & scanBits[STAGES-1];

  p_pin_roles_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones({edgeAOe, edgeBOe}) == 1);
  p_tail_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    dirSel |-> (edgeBOut == scanBits[STAGES-1] && !edgeAOut));
endmodule

// File: tb/tb_common_scan_reg.sv
module tb_common_scan_reg;
  localparam int N = 160;
  localparam int H = N / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic latchPulse = 1'b0, dirSel = 1'b1, dualSel = 1'b0;
  logic edgeAIn = 1'b0, edgeBIn = 1'b0, secondIn = 1'b0;
  logic edgeAOut, edgeAOe, edgeBOut, edgeBOe;
  logic [N-1:0] scanBits;
  logic [N-1:0] model = '0;
  int vectors = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  common_scan_reg #(.STAGES(N)) dut (
    .clk(clk), .rstN(rstN), .latchPulse(latchPulse), .dirSel(dirSel),
    .dualSel(dualSel), .edgeAIn(edgeAIn), .edgeAOut(edgeAOut), .edgeAOe(edgeAOe),
    .edgeBIn(edgeBIn), .edgeBOut(edgeBOut), .edgeBOe(edgeBOe),
    .secondIn(secondIn), .scanBits(scanBits)
  );

  function automatic logic [N-1:0] stepModel(logic [N-1:0] cur, logic fwd, logic dual,
                                               logic inA, logic inB, logic sec);
    logic [N-1:0] nx;
    if (fwd) begin
      nx = {cur[N-2:0], inA};
      if (dual) nx[H] = sec;
    end else begin
      nx = {inB, cur[N-1:1]};
      if (dual) nx[H-1] = sec;
    end
    return nx;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check(tag, scanBits, model);
    check("R7 pins", {N'(0), edgeAOe, edgeBOe, edgeAOut, edgeBOut},
          {N'(0), !dirSel, dirSel, !dirSel && model[0], dirSel && model[N-1]});
  endtask

  // one falling edge of the latch pulse; inputs stable across the shift
  task automatic pulse(logic fwd, logic dual, logic inA, logic inB, logic sec);
    @(negedge clk);
    latchPulse = 1'b1;
    dirSel = fwd; dualSel = dual;
    @(negedge clk);
    latchPulse = 1'b0;
    edgeAIn = inA; edgeBIn = inB; secondIn = sec;
    model = stepModel(model, fwd, dual, inA, inB, sec);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd7031));
    latchPulse = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset bits", scanBits, '0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");

    // R9 token traversal, single forward chain
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    checkAll("R3 token enters");
    for (int k = 1; k < N; k++) pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    checkAll("R8 ignored inputs single fwd");
    check("R9 token at tail", {N'(0), edgeBOut}, {N'(0), 1'b1});

    // R2: rising edge and long levels do nothing
    @(negedge clk); latchPulse = 1'b1; edgeAIn = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R2 high level hold");
    latchPulse = 1'b0;
    @(negedge clk);
    model = stepModel(model, 1'b1, 1'b0, 1'b1, edgeBIn, secondIn);
    repeat (4) @(negedge clk);
    checkAll("R2 single step on fall");

    // reverse single and split corners with a full-ones pattern
    for (int k = 0; k < N; k++) pulse(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    checkAll("R4 reverse fill");
    pulse(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    checkAll("R5 split fwd zero at mid");
    pulse(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    checkAll("R6 split rev one at mid");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic f, d;
      f = 1'($urandom);
      d = 1'($urandom);
      pulse(f, d, 1'($urandom), 1'($urandom), 1'($urandom));
      if (!f && !d) checkAll("R4 random");
      else if (f && !d) checkAll("R3 random");
      else if (f) checkAll("R5 random");
      else checkAll("R6 random");
    end
    finishRun();
  end
endmodule